// File: doc/BRIEF.md
# Arithmetic, Logic and Condition-Test Unit

This block is the combinational arithmetic unit of a small pipelined-or-multicycle integer core. It takes two operands, a 3-bit function code and two mode strobes. In its normal mode it adds, subtracts, or applies a bitwise AND, OR or XOR, picking the operation from the function code. In condition-test mode it compares the two operands as signed two's complement numbers under one of six relations. It then returns an operand-wide boolean: the value 1 when the relation holds and 0 when it does not.

A forced-add strobe overrides the function code and makes the unit add the operands. The control sequencer uses this for address, branch-target and link computations. Relations come from one shared subtractor plus a zero detector on its difference. That subtractor is the same one that serves the add and subtract operations. Instruction decode and the choice of which instruction field feeds the function code happen outside the block.

Top module: `alu_core`

## Requirements
- R1: With both strobes low and function code 3'b011, the result is the sum of the operands modulo 2^WIDTH.
- R2: With both strobes low and function code 3'b010, the result is first operand minus second operand modulo 2^WIDTH.
- R3: With both strobes low, function code 3'b110 gives bitwise AND, 3'b101 gives bitwise OR, and 3'b100 gives bitwise XOR of the operands.
- R4: With both strobes low, function codes 3'b000, 3'b001 and 3'b111 give an all-zero result.
- R5: With the forced-add strobe high, the result is the operand sum for every function code.
- R6: With only the test strobe high, the result's bit 0 is the outcome of a signed relation and all upper bits are zero. The code map is 3'b001 greater, 3'b010 equal, 3'b011 greater-or-equal, 3'b100 less, 3'b101 not-equal, 3'b110 less-or-equal, with the first operand on the left.
- R7: With only the test strobe high, function codes 3'b000 and 3'b111 give an all-zero result.
- R8: With both strobes high, the forced add wins and the result is the operand sum.
- R9: Signed relations stay correct when the subtraction overflows, for example the most negative value compared with the most positive value.
- R10: The result depends only on the present inputs. It settles within the cycle in which the inputs change and holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | First operand (left side of relations, minuend) |
| opb_i | input | WIDTH | Second operand |
| func_i | input | 3 | Function / relation code |
| force_add_i | input | 1 | Forces an addition regardless of func_i |
| test_en_i | input | 1 | Selects condition-test mode |
| result_o | output | WIDTH | Operation result or 0/1 test outcome |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus that produces it, with zero register stages. The bench changes the inputs just after a rising clock edge and samples result_o at the following falling edge, half a period later. That keeps every sample clear of the edge where the inputs move. A 4-bit instance is swept over every operand pair, every code and every strobe combination. A 32-bit instance using the other zero-detector variant is driven with overflow-edge operands.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

   // arithmetic / logic mode codes
   localparam logic [2:0] FN_SUB = 3'b010;
   localparam logic [2:0] FN_ADD = 3'b011;
   localparam logic [2:0] FN_XOR = 3'b100;
   localparam logic [2:0] FN_OR  = 3'b101;
   localparam logic [2:0] FN_AND = 3'b110;

   // condition-test mode codes
   localparam logic [2:0] TC_GT = 3'b001;
   localparam logic [2:0] TC_EQ = 3'b010;
   localparam logic [2:0] TC_GE = 3'b011;
   localparam logic [2:0] TC_LT = 3'b100;
   localparam logic [2:0] TC_NE = 3'b101;
   localparam logic [2:0] TC_LE = 3'b110;

   typedef enum logic [1:0] {
      MODE_ARITH = 2'd0,
      MODE_TEST  = 2'd1,
      MODE_FORCE = 2'd2
   } alu_mode_e;

   typedef struct packed {
      logic neg;   // sign bit of the difference
      logic ovf;   // signed overflow of the difference
      logic zero;  // difference is all zero
   } cmp_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] cin_vec;

   assign b_eff   = b_i ^ {WIDTH{sub_i}};
   assign cin_vec = {{(WIDTH-1){1'b0}}, sub_i};
   assign sum_o   = a_i + b_eff + cin_vec;
   assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
   parameter int WIDTH = 32,
   parameter int CHUNK = 4,
   parameter bit FLAT  = 1'b0
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             zero_o
);
   localparam int NCH  = (WIDTH + CHUNK - 1) / CHUNK;
   localparam int PADW = NCH * CHUNK;

   if (CHUNK < 1 || CHUNK > WIDTH) begin : g_bad_chunk
      $error("alu_zero_det: CHUNK must be in 1..WIDTH");
   end

   if (FLAT) begin : g_flat
      assign zero_o = ~|vec_i;
   end else begin : g_tree
      logic [PADW-1:0] padded;
      logic [NCH-1:0]  chunk_any;
      assign padded = PADW'(vec_i);
      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         assign chunk_any[c] = |padded[c*CHUNK +: CHUNK];
      end
      assign zero_o = ~|chunk_any;
   end
endmodule

// File: rtl/alu_relation.sv
module alu_relation
   import alu_core_pkg::*;
(
   input  cmp_flags_t flags_i,
   input  logic [2:0] code_i,
   output logic       holds_o
);
   logic lt, eq;

   assign lt = flags_i.neg ^ flags_i.ovf;
   assign eq = flags_i.zero;

   always_comb begin
      unique case (code_i)
         TC_GT:   holds_o = ~lt & ~eq;
         TC_EQ:   holds_o = eq;
         TC_GE:   holds_o = ~lt;
         TC_LT:   holds_o = lt;
         TC_NE:   holds_o = ~eq;
         TC_LE:   holds_o = lt | eq;
         default: holds_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_core_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       code_i,
   output logic [WIDTH-1:0] res_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (code_i)
            FN_AND:  res_o[i] = a_i[i] & b_i[i];
            FN_OR:   res_o[i] = a_i[i] | b_i[i];
            FN_XOR:  res_o[i] = a_i[i] ^ b_i[i];
            default: res_o[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_core_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ZERO_CHUNK = 4,
   parameter bit ZERO_FLAT  = 1'b0
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [2:0]       func_i,
   input  logic             force_add_i,
   input  logic             test_en_i,
   output logic [WIDTH-1:0] result_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end
   if (ZERO_CHUNK < 1 || ZERO_CHUNK > WIDTH) begin : g_bad_zchunk
      $error("alu_core: ZERO_CHUNK must be in 1..WIDTH");
   end

   alu_mode_e        mode;
   logic             sub_sel;
   logic [WIDTH-1:0] diff_sum;
   logic             diff_ovf;
   logic             diff_zero;
   logic             rel_holds;
   logic [WIDTH-1:0] bit_res;
   cmp_flags_t       flags;

   always_comb begin
      if (force_add_i)     mode = MODE_FORCE;
      else if (test_en_i)  mode = MODE_TEST;
      else                 mode = MODE_ARITH;
   end

   // one adder serves add, subtract and the comparator
   assign sub_sel = (mode == MODE_TEST) ||
                    ((mode == MODE_ARITH) && (func_i == FN_SUB));

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sub_i (sub_sel),
      .sum_o (diff_sum),
      .ovf_o (diff_ovf)
   );

   alu_zero_det #(.WIDTH(WIDTH), .CHUNK(ZERO_CHUNK), .FLAT(ZERO_FLAT)) u_zero (
      .vec_i  (diff_sum),
      .zero_o (diff_zero)
   );

   assign flags.neg  = diff_sum[MSB];
   assign flags.ovf  = diff_ovf;
   assign flags.zero = diff_zero;

   alu_relation u_rel (
      .flags_i (flags),
      .code_i  (func_i),
      .holds_o (rel_holds)
   );

   alu_bitwise #(.WIDTH(WIDTH)) u_bits (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .code_i (func_i),
      .res_o  (bit_res)
   );

   always_comb begin
      unique case (mode)
         MODE_FORCE: result_o = diff_sum;
         MODE_TEST:  result_o = {{(WIDTH-1){1'b0}}, rel_holds};
         default: begin
            unique case (func_i)
               FN_ADD, FN_SUB:        result_o = diff_sum;
               FN_AND, FN_OR, FN_XOR: result_o = bit_res;
               default:               result_o = '0;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
   import alu_core_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opa_i,
   input logic [WIDTH-1:0] opb_i,
   input logic [2:0]       func_i,
   input logic             force_add_i,
   input logic             test_en_i,
   input logic [WIDTH-1:0] result_o
);
   logic arith_mode, test_mode;
   assign arith_mode = !force_add_i && !test_en_i;
   assign test_mode  = !force_add_i && test_en_i;

   always_comb begin
      if (force_add_i) begin
         // R5 and R8: the forced add ignores func_i and the test strobe
         assert_force_add_R5: assert (result_o == WIDTH'(opa_i + opb_i))
            else $error("forced add result wrong");
      end
      if (test_mode) begin
         assert_test_bool_R6: assert (result_o[WIDTH-1:1] == '0)
            else $error("test result has upper bits set");
         if (func_i == TC_LT) begin
            assert_signed_lt_R9: assert (result_o[0] == ($signed(opa_i) < $signed(opb_i)))
               else $error("signed less-than wrong");
         end
         if (func_i == TC_EQ) begin
            assert_equal_R6: assert (result_o[0] == (opa_i == opb_i))
               else $error("equality test wrong");
         end
         if (func_i == 3'b000 || func_i == 3'b111) begin
            assert_bad_test_code_R7: assert (result_o == '0)
               else $error("unlisted test code not zero");
         end
      end
      if (arith_mode) begin
         if (func_i == 3'b000 || func_i == 3'b001 || func_i == 3'b111) begin
            assert_bad_arith_code_R4: assert (result_o == '0)
               else $error("unlisted arithmetic code not zero");
         end
         if (func_i == FN_XOR) begin
            assert_xor_R3: assert (result_o == (opa_i ^ opb_i))
               else $error("xor result wrong");
         end
         if (func_i == FN_SUB) begin
            assert_sub_R2: assert (result_o == WIDTH'(opa_i - opb_i))
               else $error("subtract result wrong");
         end
      end
   end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
   .opa_i       (opa_i),
   .opb_i       (opb_i),
   .func_i      (func_i),
   .force_add_i (force_add_i),
   .test_en_i   (test_en_i),
   .result_o    (result_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [NW-1:0] a_n, b_n, r_n;
   logic [WW-1:0] a_w, b_w, r_w;
   logic [2:0]    f_n, f_w;
   logic          add_n, tst_n, add_w, tst_w;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   alu_core #(.WIDTH(NW), .ZERO_CHUNK(3), .ZERO_FLAT(1'b0)) dut (
      .opa_i(a_n), .opb_i(b_n), .func_i(f_n),
      .force_add_i(add_n), .test_en_i(tst_n), .result_o(r_n));

   alu_core #(.WIDTH(WW), .ZERO_CHUNK(4), .ZERO_FLAT(1'b1)) dut_wide (
      .opa_i(a_w), .opb_i(b_w), .func_i(f_w),
      .force_add_i(add_w), .test_en_i(tst_w), .result_o(r_w));

   function automatic logic [31:0] model(int w, logic [31:0] a, logic [31:0] b,
                                         logic [2:0] f, logic ad, logic te);
      longint ua, ub, sa, sb, mask, r;
      mask = (64'sd1 <<< w) - 1;
      ua = longint'(a) & mask;
      ub = longint'(b) & mask;
      sa = ua[w-1] ? ua - (64'sd1 <<< w) : ua;
      sb = ub[w-1] ? ub - (64'sd1 <<< w) : ub;
      if (ad) r = ua + ub;
      else if (te) begin
         case (f)
            3'd1: r = longint'(sa >  sb);
            3'd2: r = longint'(sa == sb);
            3'd3: r = longint'(sa >= sb);
            3'd4: r = longint'(sa <  sb);
            3'd5: r = longint'(sa != sb);
            3'd6: r = longint'(sa <= sb);
            default: r = 0;
         endcase
      end else begin
         case (f)
            3'd3: r = ua + ub;
            3'd2: r = ua - ub;
            3'd6: r = ua & ub;
            3'd5: r = ua | ub;
            3'd4: r = ua ^ ub;
            default: r = 0;
         endcase
      end
      return 32'(r & mask);
   endfunction

   function automatic string req_of(logic [2:0] f, logic ad, logic te);
      if (ad && te) return "R8";
      if (ad) return "R5";
      if (te) return (f == 3'd0 || f == 3'd7) ? "R7" : "R6";
      case (f)
         3'd3: return "R1";
         3'd2: return "R2";
         3'd4, 3'd5, 3'd6: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R10 actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] wv [12];
      a_n = '0; b_n = '0; f_n = '0; add_n = 0; tst_n = 0;
      a_w = '0; b_w = '0; f_w = '0; add_w = 0; tst_w = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 / R10: idle inputs (code 000, no strobes) give zero
      check("R4", {28'd0, r_n}, 32'd0);
      check("R4", r_w, 32'd0);

      // exhaustive sweep of the narrow instance: R1..R8
      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
               for (int b = 0; b < 16; b++) begin
                  @(posedge clk);
                  a_n = NW'(a); b_n = NW'(b); f_n = 3'(f);
                  add_n = m[1]; tst_n = m[0];
                  @(negedge clk);
                  check(req_of(f_n, add_n, tst_n), {28'd0, r_n},
                        model(NW, {28'd0, a_n}, {28'd0, b_n}, f_n, add_n, tst_n));
               end
            end
         end
      end

      // wide instance: overflow edges (R9) and all modes
      wv[0] = 32'h0000_0000; wv[1] = 32'h0000_0001; wv[2] = 32'hFFFF_FFFF;
      wv[3] = 32'h7FFF_FFFF; wv[4] = 32'h8000_0000; wv[5] = 32'h8000_0001;
      wv[6] = 32'h7FFF_FFFE; wv[7] = 32'h1234_5678; wv[8] = 32'hEDCB_A988;
      wv[9] = 32'h0001_0000; wv[10] = 32'hA5A5_A5A5; wv[11] = 32'h5A5A_5A5A;
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            for (int m = 0; m < 4; m++) begin
               for (int f = 0; f < 8; f++) begin
                  @(posedge clk);
                  a_w = wv[i]; b_w = wv[j]; f_w = 3'(f);
                  add_w = m[1]; tst_w = m[0];
                  @(negedge clk);
                  if (m == 1 && f >= 1 && f <= 6 && (wv[i][31] != wv[j][31]))
                     check("R9", r_w, model(WW, a_w, b_w, f_w, add_w, tst_w));
                  else
                     check(req_of(f_w, add_w, tst_w), r_w,
                           model(WW, a_w, b_w, f_w, add_w, tst_w));
               end
            end
         end
      end

      // R10: same-cycle response after a change with no clock edge between
      @(posedge clk);
      a_w = 32'd7; b_w = 32'd9; f_w = 3'd3; add_w = 0; tst_w = 0;
      #1;
      check("R10", r_w, 32'd16);
      f_w = 3'd4; tst_w = 1;
      #1;
      check("R10", r_w, 32'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule